// File: doc/BRIEF.md
# Dual-Access Debug Flag Register

This block is an 8-bit flag register that two masters share: the processor core and the programming buffer behind a JTAG test access port. It carries a two-bit programming-source selector, a programming-enable bit and a transfer-complete flag. The selector and the enable each live in two copies: one owned by the processor and one owned by the JTAG side. The processor always reads the bitwise OR of the two copies.

The register applies the cross-clearing rules between the two owners. Any processor write wipes the JTAG selector copy. A read-only-done indication from the boot ROM wipes the JTAG enable copy. The transfer flag is set by the link logic and cleared by the debug engine.

The merged enable is latched while the processor's system reset is held. That latched bit is the boot-steering output: 1 sends execution to the in-system programming routine, and 0 sends it to user code.

Top module: `dbg_flag_reg`

## Requirements
- R1: Read data bits 7:4 are always 0. Bits 3:2 hold the selector, bit 1 the enable and bit 0 the transfer flag.
- R2: The selector read at bits 3:2 equals the OR of the processor selector copy and the JTAG selector copy.
- R3: The enable read at bit 1 equals the OR of the processor enable copy and the JTAG enable copy.
- R4: While `por_n` or `tlr_n` is low, both copies, the transfer flag and `boot_isp` are 0, asynchronously. No other input clears the selector or enable copies except by the rules below.
- R5: A clock edge with `cpu_we` high sets the JTAG selector copy to 0. This clear wins over a `jtag_ld` in the same cycle.
- R6: A clock edge with `rom_done` high sets the JTAG enable copy to 0. This clear wins over a `jtag_ld` in the same cycle, and the processor enable copy is not affected.
- R7: A clock edge with `xfer_end` high sets the transfer flag to 1, whatever `eng_clr` and `cpu_we` do in that cycle.
- R8: Without `xfer_end`, a `cpu_we` loads the flag from `cpu_wdata[0]`. Otherwise `eng_clr` clears it. Otherwise it holds.
- R9: At each edge where `sys_rst_n` is low, `boot_isp` takes the merged enable. While `sys_rst_n` is high, `boot_isp` holds its value.
- R10: `cpu_we` loads the processor copies from `cpu_wdata[3:2]` and `cpu_wdata[1]`. `jtag_ld` loads the JTAG copies from `jtag_sel` and `jtag_en`, subject to R5 and R6. Writes to bits 7:4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tlr_n | input | 1 | Test-logic reset, asynchronous, active low |
| sys_rst_n | input | 1 | Processor system reset, synchronous, active low |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (merged view) |
| jtag_ld | input | 1 | JTAG buffer load strobe |
| jtag_sel | input | 2 | JTAG selector value to load |
| jtag_en | input | 1 | JTAG enable value to load |
| xfer_end | input | 1 | End-of-transfer strobe from the link |
| eng_clr | input | 1 | Debug-engine flag clear strobe |
| rom_done | input | 1 | Read-only-done indication, clears the JTAG enable copy |
| boot_isp | output | 1 | Boot steering: 1 selects the programming routine |

## Verification
A wrong copy bit surfaces on `cpu_rdata` right after the clock edge that stored it, because the read path is a plain OR of the registers. A hidden JTAG copy stays visible only while the processor copy for the same bit is 0, so the stimulus spends long stretches with processor writes of zero. A fault in the enable merge or in the boot latch reaches `boot_isp` only once a system reset has been held, and so stimulus toggles `sys_rst_n` often. The transfer-flag priorities are checked by driving the set, clear and write strobes together.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 2;
  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int SEL_LSB  = 2;

  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_SET  = 2'd1,
    FLG_CPU  = 2'd2,
    FLG_CLR  = 2'd3
  } flag_src_t;
endpackage

// File: rtl/dfr_cpu_copy.sv
module dfr_cpu_copy #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic             wen,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (we) begin
      sel_q <= wsel;
      en_q  <= wen;
    end
  end
endmodule

// File: rtl/dfr_jtag_copy.sv
module dfr_jtag_copy #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] lsel,
  input  logic             len,
  input  logic             wipe_sel,
  input  logic             drop_en,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q
);
  for (genvar b = 0; b < SEL_W; b++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q[b] <= 1'b0;
      else if (wipe_sel) sel_q[b] <= 1'b0;
      else if (load)    sel_q[b] <= lsel[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (drop_en) en_q <= 1'b0;
    else if (load)    en_q <= len;
  end
endmodule

// File: rtl/dfr_xfer_flag.sv
module dfr_xfer_flag
  import dfr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic we,
  input  logic wbit,
  output logic q
);
  flag_src_t src;

  always_comb begin
    if (set_i)      src = FLG_SET;
    else if (we)    src = FLG_CPU;
    else if (clr_i) src = FLG_CLR;
    else            src = FLG_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else begin
      unique case (src)
        FLG_SET:  q <= 1'b1;
        FLG_CPU:  q <= wbit;
        FLG_CLR:  q <= 1'b0;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dfr_boot_latch.sv
module dfr_boot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic en_i,
  output logic boot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      boot_q <= 1'b0;
    else if (sample) boot_q <= en_i;
  end
endmodule

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg
  import dfr_pkg::*;
#(
  parameter int W_REG = dfr_pkg::REG_W,
  parameter int W_SEL = dfr_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tlr_n,
  input  logic             sys_rst_n,
  input  logic             cpu_we,
  input  logic [W_REG-1:0] cpu_wdata,
  output logic [W_REG-1:0] cpu_rdata,
  input  logic             jtag_ld,
  input  logic [W_SEL-1:0] jtag_sel,
  input  logic             jtag_en,
  input  logic             xfer_end,
  input  logic             eng_clr,
  input  logic             rom_done,
  output logic             boot_isp
);
  localparam int SEL_MSB = SEL_LSB + W_SEL - 1;
  localparam int USED_W  = SEL_MSB + 1;

  logic             rst_n;
  logic [W_SEL-1:0] cpu_sel_q, jtag_sel_q;
  logic             cpu_en_q, jtag_en_q, flag_q, merged_en;
  logic             unused_hi;

  assign rst_n     = por_n & tlr_n;
  assign unused_hi = ^cpu_wdata[W_REG-1:USED_W];

  dfr_cpu_copy #(.SEL_W(W_SEL)) u_cpu (
    .clk(clk), .rst_n(rst_n), .we(cpu_we),
    .wsel(cpu_wdata[SEL_MSB:SEL_LSB]), .wen(cpu_wdata[EN_BIT]),
    .sel_q(cpu_sel_q), .en_q(cpu_en_q)
  );

  dfr_jtag_copy #(.SEL_W(W_SEL)) u_jtag (
    .clk(clk), .rst_n(rst_n), .load(jtag_ld),
    .lsel(jtag_sel), .len(jtag_en),
    .wipe_sel(cpu_we), .drop_en(rom_done),
    .sel_q(jtag_sel_q), .en_q(jtag_en_q)
  );

  dfr_xfer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(xfer_end), .clr_i(eng_clr),
    .we(cpu_we), .wbit(cpu_wdata[FLAG_BIT]), .q(flag_q)
  );

  assign merged_en = cpu_en_q | jtag_en_q;

  dfr_boot_latch u_boot (
    .clk(clk), .rst_n(rst_n), .sample(!sys_rst_n),
    .en_i(merged_en), .boot_q(boot_isp)
  );

  always_comb begin
    cpu_rdata                  = '0;
    cpu_rdata[SEL_MSB:SEL_LSB] = cpu_sel_q | jtag_sel_q;
    cpu_rdata[EN_BIT]          = merged_en;
    cpu_rdata[FLAG_BIT]        = flag_q;
  end
endmodule

// File: rtl/dbg_flag_reg_chk.sv
module dbg_flag_reg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       tlr_n,
  input logic       sys_rst_n,
  input logic       cpu_we,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       xfer_end,
  input logic       eng_clr,
  input logic       rom_done,
  input logic       boot_isp,
  input logic [1:0] cpu_sel_q,
  input logic [1:0] jtag_sel_q,
  input logic       jtag_en_q
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    cpu_rdata[7:4] == 4'd0); // R1
  AST_WIPE_JSEL: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    cpu_we |=> jtag_sel_q == 2'd0); // R5
  AST_DROP_JEN: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    rom_done |=> !jtag_en_q); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    xfer_end |=> cpu_rdata[0]); // R7
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    (eng_clr && !xfer_end && !cpu_we) |=> !cpu_rdata[0]); // R8
  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    sys_rst_n |=> $stable(boot_isp)); // R9
  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!(por_n && tlr_n))
    cpu_we |=> cpu_sel_q == $past(cpu_wdata[3:2])); // R10
endmodule

bind dbg_flag_reg dbg_flag_reg_chk u_chk (
  .clk(clk), .por_n(por_n), .tlr_n(tlr_n), .sys_rst_n(sys_rst_n),
  .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .xfer_end(xfer_end), .eng_clr(eng_clr), .rom_done(rom_done),
  .boot_isp(boot_isp), .cpu_sel_q(cpu_sel_q), .jtag_sel_q(jtag_sel_q),
  .jtag_en_q(jtag_en_q)
);

// File: tb/sim_dbg_flag_reg.sv
module sim_dbg_flag_reg;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, tlr_n = 1'b1, sys_rst_n = 1'b0;
  logic       cpu_we = 1'b0, jtag_ld = 1'b0, jtag_en = 1'b0;
  logic       xfer_end = 1'b0, eng_clr = 1'b0, rom_done = 1'b0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [1:0] jtag_sel = 2'd0;
  logic [7:0] cpu_rdata;
  logic       boot_isp;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_csel, m_cen, m_jsel, m_jen, m_flag, m_boot;

  always #5 clk = ~clk;

  dbg_flag_reg u0 (
    .clk(clk), .por_n(por_n), .tlr_n(tlr_n), .sys_rst_n(sys_rst_n),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .jtag_ld(jtag_ld), .jtag_sel(jtag_sel), .jtag_en(jtag_en),
    .xfer_end(xfer_end), .eng_clr(eng_clr), .rom_done(rom_done),
    .boot_isp(boot_isp)
  );

  always @(posedge clk or negedge por_n or negedge tlr_n) begin
    if (!por_n || !tlr_n) begin
      m_csel = 0; m_cen = 0; m_jsel = 0; m_jen = 0; m_flag = 0; m_boot = 0;
    end else begin
      int en_now;
      en_now = m_cen | m_jen;
      if (!sys_rst_n) m_boot = en_now;
      if (xfer_end) m_flag = 1;
      else if (cpu_we) m_flag = int'(cpu_wdata[0]);
      else if (eng_clr) m_flag = 0;
      if (cpu_we) m_jsel = 0;
      else if (jtag_ld) m_jsel = int'(jtag_sel);
      if (rom_done) m_jen = 0;
      else if (jtag_ld) m_jen = int'(jtag_en);
      if (cpu_we) begin
        m_csel = int'(cpu_wdata[3:2]);
        m_cen  = int'(cpu_wdata[1]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    return ((m_csel | m_jsel) << 2) | ((m_cen | m_jen) << 1) | m_flag;
  endfunction

  task automatic compare_all();
    chk(cpu_rdata[7:4] == 4'd0, "R1 upper bits", int'(cpu_rdata[7:4]), 0);
    chk(int'(cpu_rdata[3:2]) == (m_csel | m_jsel), "R2 merged selector",
        int'(cpu_rdata[3:2]), m_csel | m_jsel);
    chk(int'(cpu_rdata[1]) == (m_cen | m_jen), "R3 merged enable",
        int'(cpu_rdata[1]), m_cen | m_jen);
    chk(int'(cpu_rdata[0]) == m_flag, "R7 R8 transfer flag", int'(cpu_rdata[0]), m_flag);
    chk(int'(boot_isp) == m_boot, "R9 boot steering", int'(boot_isp), m_boot);
  endtask

  task automatic idle();
    cpu_we = 0; jtag_ld = 0; xfer_end = 0; eng_clr = 0; rom_done = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    chk(cpu_rdata == 8'd0 && boot_isp == 1'b0, "R4 power-on reset", int'(cpu_rdata), 0);
    por_n = 1'b1;
    cyc();
    // R10: JTAG load visible, CPU copy zero
    jtag_ld = 1; jtag_sel = 2'b10; jtag_en = 1;
    cyc(); idle();
    chk(cpu_rdata[3:1] == 3'b101, "R10 jtag load", int'(cpu_rdata[3:1]), 5);
    // R9: boot latch captures while system reset low
    cyc();
    chk(boot_isp == 1'b1, "R9 boot capture", int'(boot_isp), 1);
    sys_rst_n = 1;
    // R6: read-only-done clears JTAG enable, beats a load
    rom_done = 1; jtag_ld = 1; jtag_sel = 2'b10; jtag_en = 1;
    cyc(); idle();
    chk(cpu_rdata[1] == 1'b0, "R6 jtag enable drop", int'(cpu_rdata[1]), 0);
    chk(boot_isp == 1'b1, "R9 boot hold", int'(boot_isp), 1);
    // R5: CPU write of zero wipes JTAG selector, beats a load
    cpu_we = 1; cpu_wdata = 8'hF0; jtag_ld = 1; jtag_sel = 2'b11; jtag_en = 0;
    cyc(); idle();
    chk(cpu_rdata == 8'h00, "R5 selector wipe", int'(cpu_rdata), 0);
    // R7: set wins over clear and write of 0
    xfer_end = 1; eng_clr = 1; cpu_we = 1; cpu_wdata = 8'h00;
    cyc(); idle();
    chk(cpu_rdata[0] == 1'b1, "R7 set priority", int'(cpu_rdata[0]), 1);
    // R8: write of 1 beats engine clear, then clear alone
    cpu_we = 1; cpu_wdata = 8'h07; eng_clr = 1;
    cyc(); idle();
    chk(cpu_rdata == 8'h07, "R8 write over clear", int'(cpu_rdata), 7);
    eng_clr = 1;
    cyc(); idle();
    chk(cpu_rdata == 8'h06, "R8 engine clear", int'(cpu_rdata), 6);
    // R4: test-logic reset clears everything asynchronously
    @(negedge clk); tlr_n = 0; #1;
    chk(cpu_rdata == 8'h00, "R4 test-logic reset", int'(cpu_rdata), 0);
    @(negedge clk); tlr_n = 1;
    // random phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      cyc();
      cpu_we    = ($urandom % 8) == 0;
      cpu_wdata = 8'($urandom) & (($urandom % 2) ? 8'hF3 : 8'hFF);
      jtag_ld   = ($urandom % 4) == 0;
      jtag_sel  = 2'($urandom);
      jtag_en   = 1'($urandom);
      xfer_end  = ($urandom % 5) == 0;
      eng_clr   = ($urandom % 3) == 0;
      rom_done  = ($urandom % 9) == 0;
      sys_rst_n = ($urandom % 6) != 0;
      tlr_n     = ($urandom % 150) != 0;
      por_n     = ($urandom % 300) != 0;
    end
    cyc();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule